// File: doc/BRIEF.md
# Bank Row Tracker and Page Classifier

This block holds the open/closed state and the currently open row for every bank of one memory channel, and uses that state to sort each incoming request into one of three page outcomes. A request whose bank is open on the wanted row is a hit and can go straight to a column command. A request whose bank is closed is a miss and needs an activate first. A request whose bank is open on some other row is a conflict and needs the bank closed before it can be opened again.

State changes come from single-cycle command pulses issued by the command sequencer. An activate pulse opens a bank and stores its row. A precharge pulse closes one bank. A precharge-all pulse closes every bank. The full open-bank mask and a summary bit are exported so that a refresh sequencer can decide whether a precharge is needed before refresh. The request address is split into column, bank, bank group and row by a fixed map. The outcome is registered, so it appears one cycle after the request.

Top module: `bank_page_tracker`

## Requirements
- R1: After reset every bank is closed: `open_mask` is 0, `any_open` is 0, and `pg_hit`, `pg_miss` and `pg_close` are 0.
- R2: The request address is split as column = bits [8:4], bank = bits [10:9], bank group = bits [13:11] and row = bits [28:14]. Bits [3:0] and [33:29] are ignored. A bank is numbered {bank group, bank}, so bank group g and bank b is mask bit 4*g+b. `act_bank` and `pre_bank` use the same numbering.
- R3: An `act_pulse` sets mask bit `act_bank` on the next edge and records `act_row` as that bank's open row.
- R4: A `pre_pulse` clears mask bit `pre_bank` on the next edge.
- R5: A `pre_all_pulse` clears every mask bit on the next edge, and it overrides an `act_pulse` in the same cycle.
- R6: When `act_pulse` and `pre_pulse` name the same bank in the same cycle, that bank ends closed. When they name different banks, both take effect.
- R7: A request to an open bank whose stored row equals the requested row is a hit (`pg_hit`=1).
- R8: A request to a closed bank is a miss (`pg_miss`=1).
- R9: A request to an open bank whose stored row differs from the requested row is a close (`pg_close`=1).
- R10: The flags appear one cycle after the cycle in which `req_valid` is high, and exactly one of them is 1 then. After a cycle with `req_valid` low, all three are 0.
- R11: A request is classified against the bank state as it was before any command pulse in the same cycle.
- R12: `cls_row` shows the stored row of the addressed bank when that bank was open, and 0 when it was closed. `cls_col` shows the decoded column. Both have the same latency as the flags.
- R13: `any_open` is 1 exactly when at least one bit of `open_mask` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| act_pulse | input | 1 | Activate command pulse |
| act_bank | input | 5 | Bank {group,bank} being activated |
| act_row | input | 15 | Row being activated |
| pre_pulse | input | 1 | Single-bank precharge pulse |
| pre_bank | input | 5 | Bank {group,bank} being precharged |
| pre_all_pulse | input | 1 | Precharge of every bank |
| req_valid | input | 1 | Request address present this cycle |
| req_addr | input | 34 | Request address |
| open_mask | output | 32 | One bit per bank, 1 = open |
| any_open | output | 1 | At least one bank open |
| pg_hit | output | 1 | Registered outcome: row already open |
| pg_miss | output | 1 | Registered outcome: bank closed |
| pg_close | output | 1 | Registered outcome: other row open |
| cls_row | output | 15 | Stored row of the classified bank, 0 if closed |
| cls_col | output | 5 | Column of the classified request |

## Verification
The bench targets the collision cases. It sends an activate and a precharge to one bank in the same cycle; a design that lets activate win would leave the bank open and later report a hit or close instead of a miss. It sends precharge-all together with an activate, and sends a request in the same cycle as an activate to the bank it addresses; a design with a bypass would report a hit where a miss is required. It also uses the extreme bank number 31 and the all-ones row with the ignored address bits set; a wrong field slice would light the wrong mask bit, give the wrong row, or give the wrong column.

// File: rtl/bpt_pkg.sv
package bpt_pkg;
  // Registered page outcome of one request
  typedef enum logic [1:0] {
    PG_NONE  = 2'd0,
    PG_HIT   = 2'd1,
    PG_MISS  = 2'd2,
    PG_CLOSE = 2'd3
  } page_cls_e;
endpackage

// File: rtl/bpt_addr_map.sv
module bpt_addr_map #(
  parameter int ADDR_W  = 34,
  parameter int COL_LSB = 4,
  parameter int COL_W   = 5,
  parameter int BA_LSB  = 9,
  parameter int BA_W    = 2,
  parameter int BG_LSB  = 11,
  parameter int BG_W    = 3,
  parameter int ROW_LSB = 14,
  parameter int ROW_W   = 15,
  localparam int BANK_W = BG_W + BA_W
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [BANK_W-1:0] bank_id,
  output logic [ROW_W-1:0]  row,
  output logic [COL_W-1:0]  col
);
  function automatic logic [BANK_W-1:0] f_bank(input logic [ADDR_W-1:0] a);
    logic [BG_W-1:0] g;
    logic [BA_W-1:0] b;
    g = a[BG_LSB +: BG_W];
    b = a[BA_LSB +: BA_W];
    return {g, b};
  endfunction

  function automatic logic [ROW_W-1:0] f_row(input logic [ADDR_W-1:0] a);
    return a[ROW_LSB +: ROW_W];
  endfunction

  function automatic logic [COL_W-1:0] f_col(input logic [ADDR_W-1:0] a);
    return a[COL_LSB +: COL_W];
  endfunction

  assign bank_id = f_bank(addr);
  assign row     = f_row(addr);
  assign col     = f_col(addr);
endmodule

// File: rtl/bpt_bank_table.sv
module bpt_bank_table #(
  parameter int BANK_W = 5,
  parameter int ROW_W  = 15,
  localparam int NUM_BANKS = 1 << BANK_W
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             act_pulse,
  input  logic [BANK_W-1:0]                act_bank,
  input  logic [ROW_W-1:0]                 act_row,
  input  logic                             pre_pulse,
  input  logic [BANK_W-1:0]                pre_bank,
  input  logic                             pre_all_pulse,
  output logic [NUM_BANKS-1:0]             open_mask,
  output logic [NUM_BANKS-1:0][ROW_W-1:0]  row_tab,
  output logic [NUM_BANKS-1:0]             set_vec,
  output logic [NUM_BANKS-1:0]             clr_vec
);
  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    // Closing wins over opening for the same bank in the same cycle
    assign clr_vec[b] = pre_all_pulse || (pre_pulse && (pre_bank == BANK_W'(b)));
    assign set_vec[b] = act_pulse && (act_bank == BANK_W'(b)) && !clr_vec[b];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        open_mask[b] <= 1'b0;
        row_tab[b]   <= '0;
      end else if (clr_vec[b]) begin
        open_mask[b] <= 1'b0;
      end else if (set_vec[b]) begin
        open_mask[b] <= 1'b1;
        row_tab[b]   <= act_row;
      end
    end
  end
endmodule

// File: rtl/bpt_classifier.sv
module bpt_classifier
  import bpt_pkg::*;
#(
  parameter int BANK_W = 5,
  parameter int ROW_W  = 15,
  parameter int COL_W  = 5,
  localparam int NUM_BANKS = 1 << BANK_W
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             req_valid,
  input  logic [BANK_W-1:0]                req_bank,
  input  logic [ROW_W-1:0]                 req_row,
  input  logic [COL_W-1:0]                 req_col,
  input  logic [NUM_BANKS-1:0]             open_mask,
  input  logic [NUM_BANKS-1:0][ROW_W-1:0]  row_tab,
  output page_cls_e                        cls_q,
  output logic [ROW_W-1:0]                 cls_row,
  output logic [COL_W-1:0]                 cls_col
);
  function automatic page_cls_e f_classify(input logic valid, input logic is_open,
                                           input logic [ROW_W-1:0] stored,
                                           input logic [ROW_W-1:0] wanted);
    if (!valid)             return PG_NONE;
    else if (!is_open)      return PG_MISS;
    else if (stored == wanted) return PG_HIT;
    else                    return PG_CLOSE;
  endfunction

  logic             sel_open;
  logic [ROW_W-1:0] sel_row;
  page_cls_e        cls_d;

  assign sel_open = open_mask[req_bank];
  assign sel_row  = row_tab[req_bank];
  assign cls_d    = f_classify(req_valid, sel_open, sel_row, req_row);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cls_q   <= PG_NONE;
      cls_row <= '0;
      cls_col <= '0;
    end else begin
      cls_q   <= cls_d;
      cls_row <= (req_valid && sel_open) ? sel_row : '0;
      cls_col <= req_valid ? req_col : '0;
    end
  end
endmodule

// File: rtl/bank_page_tracker.sv
module bank_page_tracker
  import bpt_pkg::*;
#(
  parameter int ADDR_W  = 34,
  parameter int COL_LSB = 4,
  parameter int COL_W   = 5,
  parameter int BA_LSB  = 9,
  parameter int BA_W    = 2,
  parameter int BG_LSB  = 11,
  parameter int BG_W    = 3,
  parameter int ROW_LSB = 14,
  parameter int ROW_W   = 15,
  localparam int BANK_W    = BG_W + BA_W,
  localparam int NUM_BANKS = 1 << BANK_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 act_pulse,
  input  logic [BANK_W-1:0]    act_bank,
  input  logic [ROW_W-1:0]     act_row,
  input  logic                 pre_pulse,
  input  logic [BANK_W-1:0]    pre_bank,
  input  logic                 pre_all_pulse,
  input  logic                 req_valid,
  input  logic [ADDR_W-1:0]    req_addr,
  output logic [NUM_BANKS-1:0] open_mask,
  output logic                 any_open,
  output logic                 pg_hit,
  output logic                 pg_miss,
  output logic                 pg_close,
  output logic [ROW_W-1:0]     cls_row,
  output logic [COL_W-1:0]     cls_col
);
  // Named internal events, visible to the bound checker
  logic [BANK_W-1:0]               req_bank;
  logic [ROW_W-1:0]                req_row;
  logic [COL_W-1:0]                req_col;
  logic [NUM_BANKS-1:0][ROW_W-1:0] row_tab;
  logic [NUM_BANKS-1:0]            set_vec;
  logic [NUM_BANKS-1:0]            clr_vec;
  page_cls_e                       cls_q;

  bpt_addr_map #(
    .ADDR_W(ADDR_W), .COL_LSB(COL_LSB), .COL_W(COL_W),
    .BA_LSB(BA_LSB), .BA_W(BA_W), .BG_LSB(BG_LSB), .BG_W(BG_W),
    .ROW_LSB(ROW_LSB), .ROW_W(ROW_W)
  ) u_map (
    .addr    (req_addr),
    .bank_id (req_bank),
    .row     (req_row),
    .col     (req_col)
  );

  bpt_bank_table #(.BANK_W(BANK_W), .ROW_W(ROW_W)) u_table (
    .clk           (clk),
    .rst_n         (rst_n),
    .act_pulse     (act_pulse),
    .act_bank      (act_bank),
    .act_row       (act_row),
    .pre_pulse     (pre_pulse),
    .pre_bank      (pre_bank),
    .pre_all_pulse (pre_all_pulse),
    .open_mask     (open_mask),
    .row_tab       (row_tab),
    .set_vec       (set_vec),
    .clr_vec       (clr_vec)
  );

  bpt_classifier #(.BANK_W(BANK_W), .ROW_W(ROW_W), .COL_W(COL_W)) u_cls (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_bank  (req_bank),
    .req_row   (req_row),
    .req_col   (req_col),
    .open_mask (open_mask),
    .row_tab   (row_tab),
    .cls_q     (cls_q),
    .cls_row   (cls_row),
    .cls_col   (cls_col)
  );

  assign any_open = |open_mask;
  assign pg_hit   = (cls_q == PG_HIT);
  assign pg_miss  = (cls_q == PG_MISS);
  assign pg_close = (cls_q == PG_CLOSE);
endmodule

// File: rtl/bpt_checker.sv
module bpt_checker #(
  parameter int BANK_W = 5,
  parameter int ROW_W  = 15,
  localparam int NUM_BANKS = 1 << BANK_W
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 act_pulse,
  input logic [BANK_W-1:0]    act_bank,
  input logic [ROW_W-1:0]     act_row,
  input logic                 pre_pulse,
  input logic [BANK_W-1:0]    pre_bank,
  input logic                 pre_all_pulse,
  input logic                 req_valid,
  input logic [NUM_BANKS-1:0] open_mask,
  input logic                 pg_hit,
  input logic                 pg_miss,
  input logic                 pg_close,
  input logic [ROW_W-1:0]     cls_row
);
  assert_act_opens_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (act_pulse && !pre_all_pulse && !(pre_pulse && pre_bank == act_bank))
      |=> open_mask[$past(act_bank)]);

  assert_pre_closes_R4: assert property (@(posedge clk) disable iff (!rst_n)
    pre_pulse |=> !open_mask[$past(pre_bank)]);

  assert_pre_all_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
    pre_all_pulse |=> (open_mask == '0));

  // R6: same-bank collision leaves the bank closed
  assert_collision_closed_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (act_pulse && pre_pulse && act_bank == pre_bank) |=> !open_mask[$past(act_bank)]);

  assert_empty_is_miss_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && open_mask == '0) |=> pg_miss);

  assert_flags_onehot0_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({pg_hit, pg_miss, pg_close}));

  assert_valid_one_flag_R10: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> ($countones({pg_hit, pg_miss, pg_close}) == 1));

  assert_idle_no_flag_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !(pg_hit || pg_miss || pg_close));

  assert_miss_row_zero_R12: assert property (@(posedge clk) disable iff (!rst_n)
    pg_miss |-> (cls_row == '0));

  // act_row is observed only to keep the interface complete
  logic unused_ok;
  assign unused_ok = ^act_row;
endmodule

bind bank_page_tracker bpt_checker #(.BANK_W(BANK_W), .ROW_W(ROW_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .act_pulse     (act_pulse),
  .act_bank      (act_bank),
  .act_row       (act_row),
  .pre_pulse     (pre_pulse),
  .pre_bank      (pre_bank),
  .pre_all_pulse (pre_all_pulse),
  .req_valid     (req_valid),
  .open_mask     (open_mask),
  .pg_hit        (pg_hit),
  .pg_miss       (pg_miss),
  .pg_close      (pg_close),
  .cls_row       (cls_row)
);

// File: tb/bank_page_tracker_tb.sv
module bank_page_tracker_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        act_pulse, pre_pulse, pre_all_pulse, req_valid;
  logic [4:0]  act_bank, pre_bank;
  logic [14:0] act_row;
  logic [33:0] req_addr;
  logic [31:0] open_mask;
  logic        any_open, pg_hit, pg_miss, pg_close;
  logic [14:0] cls_row;
  logic [4:0]  cls_col;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  bank_page_tracker u_dut (
    .clk(clk), .rst_n(rst_n),
    .act_pulse(act_pulse), .act_bank(act_bank), .act_row(act_row),
    .pre_pulse(pre_pulse), .pre_bank(pre_bank), .pre_all_pulse(pre_all_pulse),
    .req_valid(req_valid), .req_addr(req_addr),
    .open_mask(open_mask), .any_open(any_open),
    .pg_hit(pg_hit), .pg_miss(pg_miss), .pg_close(pg_close),
    .cls_row(cls_row), .cls_col(cls_col)
  );

  // Address built from the R2 field positions
  function automatic logic [33:0] mk_addr(input int g, input int b, input int row, input int col);
    logic [33:0] a;
    a = '0;
    a[13:11] = 3'(g);
    a[10:9]  = 2'(b);
    a[28:14] = 15'(row);
    a[8:4]   = 5'(col);
    return a;
  endfunction

  task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, got, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle_inputs();
    act_pulse = 0; pre_pulse = 0; pre_all_pulse = 0; req_valid = 0;
    act_bank = '0; pre_bank = '0; act_row = '0; req_addr = '0;
  endtask

  task automatic do_act(input int bank, input int row);
    act_pulse = 1; act_bank = 5'(bank); act_row = 15'(row);
    step();
    idle_inputs();
  endtask

  task automatic do_pre(input int bank);
    pre_pulse = 1; pre_bank = 5'(bank);
    step();
    idle_inputs();
  endtask

  // Request, then compare flags {hit,miss,close} and cls_row one cycle later
  task automatic do_req(input string tag, input logic [33:0] a, input logic [2:0] exp_f,
                        input int exp_row);
    req_valid = 1; req_addr = a;
    step();
    idle_inputs();
    chk(tag, {pg_hit, pg_miss, pg_close}, exp_f);
    chk({tag, " row"}, cls_row, 64'(exp_row));
  endtask

  task automatic t_reset();
    chk("R1 mask", open_mask, 0);
    chk("R1 any", any_open, 0);
    chk("R1 flags", {pg_hit, pg_miss, pg_close}, 0);
  endtask

  task automatic t_open_hit();
    do_act(5, 16'h1234);
    chk("R3 mask bit5", open_mask, 32'h20);
    chk("R13 any", any_open, 1);
    do_req("R7 hit", mk_addr(1, 1, 16'h1234, 9), 3'b100, 16'h1234);
    chk("R12 col", cls_col, 9);
  endtask

  task automatic t_miss_close();
    do_req("R8 miss", mk_addr(1, 3, 16'h1234, 0), 3'b010, 0);
    do_req("R9 close", mk_addr(1, 1, 16'h0001, 2), 3'b001, 16'h1234);
  endtask

  task automatic t_no_req();
    step();
    chk("R10 idle flags", {pg_hit, pg_miss, pg_close}, 0);
  endtask

  task automatic t_precharge();
    do_pre(5);
    chk("R4 mask", open_mask, 0);
    chk("R13 any low", any_open, 0);
    do_req("R4 miss after pre", mk_addr(1, 1, 16'h1234, 0), 3'b010, 0);
  endtask

  task automatic t_collision();
    act_pulse = 1; act_bank = 5'd3; act_row = 15'd77;
    pre_pulse = 1; pre_bank = 5'd3;
    step();
    idle_inputs();
    chk("R6 same bank closed", open_mask, 0);
    do_req("R6 same bank miss", mk_addr(0, 3, 77, 0), 3'b010, 0);
    do_act(4, 10);
    act_pulse = 1; act_bank = 5'd2; act_row = 15'd20;
    pre_pulse = 1; pre_bank = 5'd4;
    step();
    idle_inputs();
    chk("R6 diff banks", open_mask, 32'h4);
  endtask

  task automatic t_pre_all();
    do_act(17, 1);
    do_act(30, 2);
    act_pulse = 1; act_bank = 5'd9; act_row = 15'd3;
    pre_all_pulse = 1;
    step();
    idle_inputs();
    chk("R5 all clear", open_mask, 0);
    chk("R5 any", any_open, 0);
  endtask

  task automatic t_same_cycle_req();
    req_valid = 1; req_addr = mk_addr(2, 2, 500, 1);
    act_pulse = 1; act_bank = 5'd10; act_row = 15'd500;
    step();
    idle_inputs();
    chk("R11 old state miss", {pg_hit, pg_miss, pg_close}, 3'b010);
    do_req("R11 later hit", mk_addr(2, 2, 500, 1), 3'b100, 500);
    do_pre(10);
  endtask

  task automatic t_field_edges();
    logic [33:0] a;
    do_act(31, 16'h7FFF);
    chk("R2 bank31 bit", open_mask, 32'h8000_0000);
    a = mk_addr(7, 3, 16'h7FFF, 31);
    a[33:29] = '1;
    a[3:0] = '1;
    do_req("R2 edge hit", a, 3'b100, 16'h7FFF);
    chk("R2 col31", cls_col, 31);
    do_req("R2 row bit0 differs", mk_addr(7, 3, 16'h7FFE, 0), 3'b001, 16'h7FFF);
  endtask

  initial begin
    idle_inputs();
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_open_hit();
    t_miss_close();
    t_no_req();
    t_precharge();
    t_collision();
    t_pre_all();
    t_same_cycle_req();
    t_field_edges();
    repeat (2) step();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule